// File: doc/BRIEF.md
# Serial Flash Command Engine

This block runs one short command on a serial flash device, fully described by a single 32-bit control word. Software first loads an address word and up to eight bytes of outgoing data, then writes the control word twice: once to set the fields, and once more with the start bit set. The engine then drives a single-bit serial link. It sends the opcode, then the optional address bytes and the optional idle (dummy) cycles. After that it sends the outgoing data and/or collects the incoming data.

Bit timing is set from outside through a clock-enable input. Every cycle in which that input is high, while a command runs, moves exactly one bit. Incoming bytes are packed little-endian into a 64-bit result that is visible as a lower word and an upper word. A busy flag is visible in the control readback while the command runs.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, `cs_no` is 1, `sdo_o` is 0, and `ctrl_o`, `rdata_lo_o` and `rdata_hi_o` are all zero.
- R2: A register write with `wr_sel_i`=0 stores the control word. Its fields are: opcode [31:24], read enable [23], read byte count minus one [22:20], address enable [19], address byte count minus one [17:16], write enable [15], write byte count minus one [14:12], dummy cycle count [11:7], start [0]. When idle and [0]=0, `ctrl_o` returns the written word with [1:0] cleared, and no command starts.
- R3: A control write with [0]=1 while idle starts a command. From the next cycle `cs_no` is 0 and `ctrl_o[1]` is 1. Both return to idle in the cycle after the clock edge that moves the last bit.
- R4: While a command runs, each clock edge with `sclk_en_i` high moves one bit and pulses `sck_o`. With `sclk_en_i` low the command waits and holds its state. Every byte is sent and received most significant bit first. `sdo_o` presents the bit before the edge, and `sdi_i` is sampled on that edge.
- R5: Phases run in a fixed order: opcode, address if [19], dummy cycles if [11:7] is nonzero, write data if [15], read data if [23]. Disabled phases take no bits. `sdo_o` is 0 during dummy cycles, during the read phase and while idle.
- R6: The address phase sends [17:16]+1 bytes, taken from the low bytes of the address register (`wr_sel_i`=1), most significant of those bytes first.
- R7: The write phase sends [14:12]+1 bytes. Byte k comes from bits [8k+7:8k] of the 64-bit value formed by the upper data word (`wr_sel_i`=3) above the lower data word (`wr_sel_i`=2).
- R8: The read phase receives [22:20]+1 bytes. Byte k lands in bits [8k+7:8k] of {`rdata_hi_o`,`rdata_lo_o`}. Starting a command clears both words, so bytes that are not received read as zero, and the words change only on bit edges or at a start.
- R9: A control write while a command runs is ignored completely: the stored fields are unchanged, and a start bit in it launches nothing.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 control, 1 address, 2 write data low, 3 write data high |
| wr_data_i | input | 32 | Register write value |
| sclk_en_i | input | 1 | Bit-rate enable; one bit moves per high cycle |
| sdi_i | input | 1 | Serial data from the device |
| ctrl_o | output | 32 | Control readback; bit 1 is busy, bit 0 reads 0 |
| rdata_lo_o | output | 32 | Received bytes 0 to 3 |
| rdata_hi_o | output | 32 | Received bytes 4 to 7 |
| cs_no | output | 1 | Device select, active low |
| sck_o | output | 1 | Bit strobe: high in each cycle where a bit moves |
| sdo_o | output | 1 | Serial data to the device |

## Verification
The interesting collision is a control write with the start bit set that arrives in the same cycle as the final bit edge of a running command. Busy is still high in that cycle, so the write must be ignored rather than queued.

The bench provokes this by asserting the register write together with the eighth enable pulse of an opcode-only command. It then checks three things: the stored opcode is unchanged, the select line stays released for several cycles afterwards, and exactly eight bits moved. The same sequence also places a field-changing write in the middle of the command and checks that the readback does not move.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned CNT_W      = 3;
  localparam int unsigned ACNT_W     = 2;
  localparam int unsigned DMY_W      = 5;
  localparam int unsigned DATA_BYTES = 1 << CNT_W;
  localparam int unsigned ADDR_BYTES = 1 << ACNT_W;

  localparam int unsigned OPC_LSB    = 24;
  localparam int unsigned RD_EN_BIT  = 23;
  localparam int unsigned RD_CNT_LSB = 20;
  localparam int unsigned AD_EN_BIT  = 19;
  localparam int unsigned AD_CNT_LSB = 16;
  localparam int unsigned WR_EN_BIT  = 15;
  localparam int unsigned WR_CNT_LSB = 12;
  localparam int unsigned DMY_LSB    = 7;
  localparam int unsigned BUSY_BIT   = 1;
  localparam int unsigned GO_BIT     = 0;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_WLO  = 2'd2;
  localparam logic [1:0] SEL_WHI  = 2'd3;

  // Encoding order is the phase order
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_OPC  = 3'd1,
    PH_ADR  = 3'd2,
    PH_DMY  = 3'd3,
    PH_WR   = 3'd4,
    PH_RD   = 3'd5
  } phase_e;

  localparam int unsigned PH_FIRST_OPT = 2;
  localparam int unsigned PH_LAST      = 5;

  typedef struct packed {
    logic [BYTE_W-1:0] opcode;
    logic              rd_en;
    logic [CNT_W-1:0]  rd_m1;
    logic              ad_en;
    logic [ACNT_W-1:0] ad_m1;
    logic              wr_en;
    logic [CNT_W-1:0]  wr_m1;
    logic [DMY_W-1:0]  dummy;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [REG_W-1:0] w);
    cmd_t c;
    c.opcode = w[OPC_LSB +: BYTE_W];
    c.rd_en  = w[RD_EN_BIT];
    c.rd_m1  = w[RD_CNT_LSB +: CNT_W];
    c.ad_en  = w[AD_EN_BIT];
    c.ad_m1  = w[AD_CNT_LSB +: ACNT_W];
    c.wr_en  = w[WR_EN_BIT];
    c.wr_m1  = w[WR_CNT_LSB +: CNT_W];
    c.dummy  = w[DMY_LSB +: DMY_W];
    return c;
  endfunction

  function automatic logic phase_used(input phase_e p, input cmd_t c);
    logic r;
    case (p)
      PH_OPC:  r = 1'b1;
      PH_ADR:  r = c.ad_en;
      PH_DMY:  r = (c.dummy != '0);
      PH_WR:   r = c.wr_en;
      PH_RD:   r = c.rd_en;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  // First enabled phase after cur, lowest encoding wins
  function automatic phase_e phase_after(input phase_e cur, input cmd_t c);
    phase_e r;
    r = PH_IDLE;
    for (int i = PH_LAST; i >= PH_FIRST_OPT; i--) begin
      if (i > int'(cur) && phase_used(phase_e'(3'(i)), c)) r = phase_e'(3'(i));
    end
    return r;
  endfunction
endpackage

// File: rtl/fcmd_seq.sv
module fcmd_seq
  import fcmd_pkg::*;
#(
  parameter int unsigned BW      = 8,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned DCNT_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  cmd_t             cmd_i,
  output logic             busy_o,
  output phase_e           phase_o,
  output logic             load_o,
  output phase_e           ld_phase_o,
  output logic [IDX_W-1:0] ld_idx_o,
  output logic             rx_we_o,
  output logic [IDX_W-1:0] rx_idx_o
);
  localparam int unsigned BIT_W = $clog2(BW);
  localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(BW - 1);

  phase_e              ph_q, ph_d, ph_nxt;
  logic [BIT_W-1:0]    bit_q, bit_d;
  logic [IDX_W-1:0]    idx_q, idx_d, last_idx;
  logic [DCNT_W-1:0]   dcnt_q, dcnt_d;
  logic                busy, step, byte_end, ph_end;

  assign busy     = (ph_q != PH_IDLE);
  assign step     = tick_i && busy;
  assign byte_end = step && (ph_q != PH_DMY) && (bit_q == '0);
  assign ph_nxt   = phase_after(ph_q, cmd_i);

  always_comb begin
    case (ph_q)
      PH_ADR:  last_idx = IDX_W'(cmd_i.ad_m1);
      PH_WR:   last_idx = IDX_W'(cmd_i.wr_m1);
      PH_RD:   last_idx = IDX_W'(cmd_i.rd_m1);
      default: last_idx = '0;
    endcase
  end

  assign ph_end = (ph_q == PH_DMY) ? (step && dcnt_q == DCNT_W'(1))
                                   : (byte_end && idx_q == last_idx);

  always_comb begin
    ph_d       = ph_q;
    bit_d      = bit_q;
    idx_d      = idx_q;
    dcnt_d     = dcnt_q;
    load_o     = 1'b0;
    ld_phase_o = ph_q;
    ld_idx_o   = idx_q + IDX_W'(1);
    if (start_i && !busy) begin
      ph_d       = PH_OPC;
      bit_d      = BIT_TOP;
      idx_d      = '0;
      load_o     = 1'b1;
      ld_phase_o = PH_OPC;
      ld_idx_o   = '0;
    end else if (ph_end) begin
      ph_d       = ph_nxt;
      bit_d      = BIT_TOP;
      idx_d      = '0;
      ld_phase_o = ph_nxt;
      ld_idx_o   = '0;
      if (ph_nxt == PH_DMY) dcnt_d = DCNT_W'(cmd_i.dummy);
      else if (ph_nxt != PH_IDLE) load_o = 1'b1;
    end else if (byte_end) begin
      bit_d  = BIT_TOP;
      idx_d  = idx_q + IDX_W'(1);
      load_o = 1'b1;
    end else if (step) begin
      if (ph_q == PH_DMY) dcnt_d = dcnt_q - DCNT_W'(1);
      else bit_d = bit_q - BIT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      bit_q  <= '0;
      idx_q  <= '0;
      dcnt_q <= '0;
    end else begin
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      idx_q  <= idx_d;
      dcnt_q <= dcnt_d;
    end
  end

  assign busy_o   = busy;
  assign phase_o  = ph_q;
  assign rx_we_o  = byte_end && (ph_q == PH_RD);
  assign rx_idx_o = idx_q;
endmodule

// File: rtl/fcmd_shift.sv
module fcmd_shift #(
  parameter int unsigned BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [BW-1:0] load_val_i,
  input  logic          shift_i,
  input  logic          sdi_i,
  output logic          msb_o,
  output logic [BW-1:0] rx_byte_o
);
  logic [BW-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= load_val_i;
    else if (shift_i) sh_q <= {sh_q[BW-2:0], sdi_i};
  end

  assign msb_o     = sh_q[BW-1];
  assign rx_byte_o = {sh_q[BW-2:0], sdi_i};
endmodule

// File: rtl/fcmd_rxpack.sv
module fcmd_rxpack #(
  parameter int unsigned NBYTES = 8,
  parameter int unsigned BW     = 8,
  localparam int unsigned IDX_W = $clog2(NBYTES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 we_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [BW-1:0]        byte_i,
  output logic [NBYTES*BW-1:0] data_o
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [BW-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      byte_q <= '0;
      else if (clr_i)                                   byte_q <= '0;
      else if (we_i && idx_i == IDX_W'(b))              byte_q <= byte_i;
    end
    assign data_o[b*BW +: BW] = byte_q;
  end
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import fcmd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  wr_sel_i,
  input  logic [31:0] wr_data_i,
  input  logic        sclk_en_i,
  input  logic        sdi_i,
  output logic [31:0] ctrl_o,
  output logic [31:0] rdata_lo_o,
  output logic [31:0] rdata_hi_o,
  output logic        cs_no,
  output logic        sck_o,
  output logic        sdo_o
);
  localparam int unsigned DW = DATA_BYTES * BYTE_W;

  logic [REG_W-1:0]  ctrl_q, addr_q;
  logic [DW-1:0]     wdat_q, rdat;
  logic              busy, ctrl_wr, start, load, rx_we, tx_msb;
  cmd_t              cmd;
  phase_e            phase, ld_phase;
  logic [CNT_W-1:0]  ld_idx, rx_idx;
  logic [ACNT_W-1:0] a_sel;
  logic [BYTE_W-1:0] ld_val, rx_byte;
  logic [BYTE_W-1:0] addr_b [ADDR_BYTES];
  logic [BYTE_W-1:0] wdat_b [DATA_BYTES];

  assign ctrl_wr = wr_en_i && (wr_sel_i == SEL_CTRL) && !busy;
  assign start   = ctrl_wr && wr_data_i[GO_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      addr_q <= '0;
      wdat_q <= '0;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        SEL_CTRL: if (!busy) ctrl_q <= {wr_data_i[REG_W-1:2], 2'b00};
        SEL_ADDR: addr_q <= wr_data_i;
        SEL_WLO:  wdat_q[0 +: REG_W] <= wr_data_i;
        default:  wdat_q[REG_W +: REG_W] <= wr_data_i;
      endcase
    end
  end

  // Fields come straight from the bus on the starting write
  assign cmd = decode_cmd(start ? wr_data_i : ctrl_q);

  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_abyte
    assign addr_b[b] = addr_q[b*BYTE_W +: BYTE_W];
  end
  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_wbyte
    assign wdat_b[b] = wdat_q[b*BYTE_W +: BYTE_W];
  end

  // Address goes out most significant selected byte first
  assign a_sel = cmd.ad_m1 - ld_idx[ACNT_W-1:0];

  always_comb begin
    case (ld_phase)
      PH_OPC:  ld_val = cmd.opcode;
      PH_ADR:  ld_val = addr_b[a_sel];
      PH_WR:   ld_val = wdat_b[ld_idx];
      default: ld_val = '0;
    endcase
  end

  fcmd_seq #(
    .BW     (BYTE_W),
    .IDX_W  (CNT_W),
    .DCNT_W (DMY_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .tick_i     (sclk_en_i),
    .cmd_i      (cmd),
    .busy_o     (busy),
    .phase_o    (phase),
    .load_o     (load),
    .ld_phase_o (ld_phase),
    .ld_idx_o   (ld_idx),
    .rx_we_o    (rx_we),
    .rx_idx_o   (rx_idx)
  );

  fcmd_shift #(.BW(BYTE_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (ld_val),
    .shift_i    (sclk_en_i && busy),
    .sdi_i      (sdi_i),
    .msb_o      (tx_msb),
    .rx_byte_o  (rx_byte)
  );

  fcmd_rxpack #(.NBYTES(DATA_BYTES), .BW(BYTE_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .we_i   (rx_we),
    .idx_i  (rx_idx),
    .byte_i (rx_byte),
    .data_o (rdat)
  );

  assign ctrl_o     = {ctrl_q[REG_W-1:2], busy, 1'b0};
  assign rdata_lo_o = rdat[0 +: REG_W];
  assign rdata_hi_o = rdat[REG_W +: REG_W];
  assign cs_no      = !busy;
  assign sck_o      = sclk_en_i && busy;
  assign sdo_o      = tx_msb && (phase == PH_OPC || phase == PH_ADR || phase == PH_WR);
endmodule

// File: rtl/fcmd_chk.sv
module fcmd_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [1:0]  wr_sel_i,
  input logic [31:0] wr_data_i,
  input logic        sclk_en_i,
  input logic [31:0] ctrl_o,
  input logic [31:0] rdata_lo_o,
  input logic [31:0] rdata_hi_o,
  input logic        cs_no,
  input logic        sck_o,
  input logic        sdo_o
);
  // R3
  start_needs_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(wr_en_i && wr_sel_i == 2'd0 && wr_data_i[0]));

  // R9
  fields_hold_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && $past(!cs_no)) |-> (ctrl_o[31:2] == $past(ctrl_o[31:2])));

  // R5
  sdo_quiet_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sdo_o);

  // R4
  no_end_without_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && !sclk_en_i) |=> !cs_no);

  // R8
  rdata_moves_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({rdata_hi_o, rdata_lo_o}) |-> ($past(sck_o) || $fell(cs_no)));
endmodule

bind flash_cmd_engine fcmd_chk u_chk (.*);

// File: tb/sim_flash_cmd_engine.sv
module sim_flash_cmd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        sclk_en = 1'b0;
  logic        sdi;
  logic [31:0] ctrl, rlo, rhi;
  logic        cs_n, sck, sdo;

  always #5 clk = ~clk;

  flash_cmd_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .sclk_en_i(sclk_en), .sdi_i(sdi),
    .ctrl_o(ctrl), .rdata_lo_o(rlo), .rdata_hi_o(rhi),
    .cs_no(cs_n), .sck_o(sck), .sdo_o(sdo)
  );

  int n_chk = 0, n_bad = 0;

  // Device model: records sent bits, returns resp bytes after pre_bits
  logic        tb_clr = 1'b0;
  int          tcnt = 0;
  int          pre_bits = 0;
  logic [63:0] resp = '0;
  logic        mosi [256];
  logic        expb [256];
  int          k_rx;

  always @(posedge clk) begin
    if (tb_clr) tcnt <= 0;
    else if (sck) begin
      if (tcnt < 256) mosi[tcnt] <= sdo;
      tcnt <= tcnt + 1;
    end
  end

  always_comb begin
    k_rx = tcnt - pre_bits;
    if (k_rx >= 0 && k_rx < 64) sdi = resp[(k_rx / 8) * 8 + 7 - (k_rx % 8)];
    else sdi = 1'b0;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clr_model();
    tb_clr = 1'b1;
    @(negedge clk);
    tb_clr = 1'b0;
  endtask

  function automatic logic [31:0] mk(input logic [7:0] op, input bit rd, input int rb,
                                     input bit ad, input int ab, input bit wr, input int wb,
                                     input int dmy, input bit go);
    logic [2:0] rbm, wbm;
    logic [1:0] abm;
    rbm = (rb > 0) ? 3'(rb - 1) : 3'd0;
    wbm = (wb > 0) ? 3'(wb - 1) : 3'd0;
    abm = (ab > 0) ? 2'(ab - 1) : 2'd0;
    return {op, rd, rbm, ad, 1'b0, abm, wr, wbm, 5'(dmy), 5'd0, 1'b0, go};
  endfunction

  task automatic run_cmd(input string name, input logic [7:0] op,
                         input bit ad, input int ab, input logic [31:0] addr,
                         input int dmy, input bit wr, input int wb, input logic [63:0] wd,
                         input bit rd, input int rb, input logic [63:0] rsp, input int period);
    logic [31:0] c;
    logic [63:0] exp_rd;
    int total, pos, cyc, late, mism;
    c = mk(op, rd, rb, ad, ab, wr, wb, dmy, 1'b0);
    pre_bits = 8 + (ad ? 8 * ab : 0) + dmy + (wr ? 8 * wb : 0);
    total = pre_bits + (rd ? 8 * rb : 0);
    for (int i = 0; i < 256; i++) expb[i] = 1'b0;
    pos = 0;
    for (int b = 7; b >= 0; b--) begin expb[pos] = op[b]; pos++; end
    if (ad) for (int j = ab - 1; j >= 0; j--)
      for (int b = 7; b >= 0; b--) begin expb[pos] = addr[j*8 + b]; pos++; end
    pos = pos + dmy;
    if (wr) for (int j = 0; j < wb; j++)
      for (int b = 7; b >= 0; b--) begin expb[pos] = wd[j*8 + b]; pos++; end
    exp_rd = '0;
    if (rd) for (int j = 0; j < rb; j++) exp_rd[j*8 +: 8] = rsp[j*8 +: 8];
    resp = rsp;
    clr_model();
    wr_reg(2'd1, addr);
    wr_reg(2'd2, wd[31:0]);
    wr_reg(2'd3, wd[63:32]);
    wr_reg(2'd0, c);
    chk({name, " R2 ctrl readback"}, 64'(ctrl), 64'(c));
    chk({name, " R2 no start without go"}, 64'(cs_n), 64'd1);
    wr_reg(2'd0, c | 32'h1);
    chk({name, " R3 select active"}, 64'(cs_n), 64'd0);
    chk({name, " R3 busy bit"}, 64'(ctrl[1]), 64'd1);
    cyc = 0; late = 0;
    while (cs_n == 1'b0 && cyc < 5000) begin
      sclk_en = (cyc % period == 0);
      @(negedge clk);
      if (tcnt == total && cs_n == 1'b0) late++;
      cyc++;
    end
    sclk_en = 1'b0;
    chk({name, " R3 release after last bit"}, 64'(late), 64'd0);
    chk({name, " R4 bit count"}, 64'(tcnt), 64'(total));
    mism = 0;
    for (int i = 0; i < total && i < 256; i++) if (mosi[i] !== expb[i]) mism++;
    chk({name, " R5 R6 R7 serial stream mismatches"}, 64'(mism), 64'd0);
    chk({name, " R8 read data"}, {rhi, rlo}, exp_rd);
    chk({name, " R3 busy cleared"}, 64'(ctrl[1]), 64'd0);
  endtask

  task automatic t_reset();
    chk("R1 select idle", 64'(cs_n), 64'd1);
    chk("R1 sdo low", 64'(sdo), 64'd0);
    chk("R1 ctrl zero", 64'(ctrl), 64'd0);
    chk("R1 read data zero", {rhi, rlo}, 64'd0);
  endtask

  task automatic t_collide();
    logic [31:0] c, other;
    int idle_bad;
    c = mk(8'h05, 0, 0, 0, 0, 0, 0, 0, 1'b0);
    other = mk(8'hAB, 1, 4, 1, 3, 0, 0, 6, 1'b0);
    pre_bits = 8;
    clr_model();
    wr_reg(2'd0, c);
    wr_reg(2'd0, c | 32'h1);
    repeat (10) @(negedge clk);
    chk("R4 stall holds select", 64'(cs_n), 64'd0);
    chk("R4 stall moves no bits", 64'(tcnt), 64'd0);
    for (int i = 0; i < 8; i++) begin
      sclk_en = 1'b1;
      if (i == 3) begin wr_en = 1'b1; wr_sel = 2'd0; wr_data = other; end
      else if (i == 7) begin wr_en = 1'b1; wr_sel = 2'd0; wr_data = other | 32'h1; end
      else wr_en = 1'b0;
      @(negedge clk);
    end
    sclk_en = 1'b0; wr_en = 1'b0;
    chk("R3 collide ends on eighth edge", 64'(cs_n), 64'd1);
    chk("R9 fields unchanged", 64'(ctrl), 64'(c));
    chk("R4 collide bit count", 64'(tcnt), 64'd8);
    idle_bad = 0;
    repeat (5) begin @(negedge clk); if (!cs_n) idle_bad++; end
    chk("R9 no late start", 64'(idle_bad), 64'd0);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog R3 run did not finish actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_cmd("opc", 8'h06, 0, 0, 32'h0, 0, 0, 0, 64'h0, 0, 0, 64'h0, 1);
    run_cmd("rd8", 8'h0B, 1, 3, 32'h00A1B2C3, 8, 0, 0, 64'h0,
            1, 8, 64'h0123_4567_89AB_CDEF, 3);
    run_cmd("rd3", 8'h9F, 0, 0, 32'h0, 0, 0, 0, 64'h0,
            1, 3, 64'hFFFF_FFFF_FFC2_20EF, 1);
    run_cmd("wr8", 8'h02, 1, 4, 32'hDEAD_BEEF, 0, 1, 8, 64'h8877_6655_4433_2211,
            0, 0, 64'h0, 2);
    run_cmd("mix", 8'h5A, 1, 1, 32'h0000_0077, 1, 1, 5, 64'h0000_00E5_D4C3_B2A1,
            1, 2, 64'h0000_0000_0000_3CC3, 1);
    run_cmd("dmy", 8'hEB, 1, 2, 32'h0000_4321, 31, 0, 0, 64'h0,
            1, 1, 64'h0000_0000_0000_0081, 2);
    t_collide();
    report();
    $finish;
  end
endmodule